// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This host-side controller drives a byte-wide parallel flash device on behalf of a simple request port. A request carries an operation selector (byte program or sector erase), a 19-bit byte address and a data byte. The sequencer turns that request into the full bus protocol. The first request after reset is preceded by a fixed seven-read unlock sequence. Next come a two-write command. The sequencer then polls the target address until the device reports completion. It ends by raising `done_o`, with `error_o` set if the operation was abandoned.

The flash strobes (chip select, output enable and write enable, all active low), the address and a split data bus with an output-enable qualifier are generated by a cycle engine whose setup, strobe and hold widths are clock-count parameters. Completion is recognised in either of two ways: bit 7 of a status read matches the expected final value, or two successive status reads show bit 6 unchanged. A timeout counter bounds each polling phase. An erase that does not finish in time is cancelled and issued again, up to a retry limit. A program that does not finish in time is cancelled and reported as an error.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, `flash_ce_no`, `flash_oe_no` and `flash_we_no` are high, `flash_dq_oe_o` and `done_o` are low, and `ready_o` is high.
- R2: Before its first write, the first accepted request issues exactly seven reads, at addresses 01823h, 01820h, 01822h, 00418h, 01B23h, 00419h, 0041Ah in that order. Later requests issue no unlock reads.
- R3: An erase (`req_erase_i`=1) writes 20h and then D0h, the D0h write being at the request address.
- R4: A program (`req_erase_i`=0) writes 10h and then the request data byte, the data write being at the full request address.
- R5: A write cycle lowers WE only while CE is low and OE is high. Address and data stay stable while WE is low. WE returns high before CE rises.
- R6: The data bus is driven (`flash_dq_oe_o`=1) only while OE is high, and it is released whenever CE is high.
- R7: A status read whose bit 7 equals the expected value ends the operation without error. The expected value is the programmed bit 7 for a program and 1 for an erase.
- R8: Two successive status reads with equal bit 6 end the operation without error, even when bit 7 never matches.
- R9: An erase still busy when the erase timeout expires is followed by a write of FFh and a fresh 20h/D0h pair. After MAX_RETRY such retries fail, `done_o` rises with `error_o`=1.
- R10: A program still busy when the program timeout expires is followed by a write of FFh, then `done_o` with `error_o`=1 and no retry.
- R11: `done_o` stays high until `ack_i`. While it is high, `ready_o` is low, and a request presented then causes no bus write.
- R12: Status reads are issued at the request address with OE low and WE high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_erase_i | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr_i | input | AW | Target byte address |
| req_data_i | input | DW | Byte to program |
| ready_o | output | 1 | Idle, request accepted when valid |
| done_o | output | 1 | Operation finished, held until acknowledged |
| error_o | output | 1 | Operation abandoned, valid with done_o |
| ack_i | input | 1 | Acknowledge of done_o |
| flash_ce_no | output | 1 | Flash chip select, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | DW | Data driven toward the flash |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_dq_i | input | DW | Data read from the flash |

## Verification
A wrong sequencer state shows up at the ports as a wrong or missing write value on the next WE rising edge, within one bus cycle. A lost unlock index shows as a read at an unexpected address before the first write. A faulty completion test shows either as an early `done_o` or as a spurious FFh cancel write after the timeout window, a few hundred cycles at the bench settings. A strobe-ordering or bus-release fault in the cycle engine is visible in the very cycle it occurs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int UNLK_LEN = 7;
  localparam logic [7:0] CMD_PROG    = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CANCEL  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_UNLK, S_SETUPW, S_EXECW, S_POLL, S_CANCEL, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_GAP
  } bus_state_e;

  function automatic logic [18:0] unlock_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    return 19'h01823;
      3'd1:    return 19'h01820;
      3'd2:    return 19'h01822;
      3'd3:    return 19'h00418;
      3'd4:    return 19'h01B23;
      3'd5:    return 19'h00419;
      default: return 19'h0041A;
    endcase
  endfunction
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 4,
  parameter int T_HOLD  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          ce_no,
  output logic          oe_no,
  output logic          we_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i
);
  localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                            : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int CW = $clog2(TMAX + 1);

  bus_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= B_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      ce_no   <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        B_IDLE: if (start_i) begin
          addr_o  <= addr_i;
          dq_o    <= wdata_i;
          wr_q    <= wr_i;
          ce_no   <= 1'b0;
          dq_oe_o <= wr_i;
          cnt_q   <= CW'(T_SETUP - 1);
          state_q <= B_SETUP;
        end
        B_SETUP: begin
          if (cnt_q == '0) begin
            if (wr_q) we_no <= 1'b0;
            else      oe_no <= 1'b0;
            cnt_q   <= CW'(T_PULSE - 1);
            state_q <= B_PULSE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        B_PULSE: begin
          if (cnt_q == '0) begin
            we_no <= 1'b1;
            oe_no <= 1'b1;
            if (!wr_q) rdata_o <= dq_i;
            cnt_q   <= CW'(T_HOLD - 1);
            state_q <= B_HOLD;
          end else cnt_q <= cnt_q - 1'b1;
        end
        B_HOLD: begin
          // data held past WE rise; CE released last
          if (cnt_q == '0) begin
            ce_no   <= 1'b1;
            dq_oe_o <= 1'b0;
            done_o  <= 1'b1;
            state_q <= B_GAP;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_timeout.sv
module flash_timeout #(
  parameter int CW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int AW           = 19,
  parameter int DW           = 8,
  parameter int T_SETUP      = 2,
  parameter int T_PULSE      = 4,
  parameter int T_HOLD       = 2,
  parameter int PROG_TO_CYC  = 4375,
  parameter int ERASE_TO_CYC = 500000,
  parameter int MAX_RETRY    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_erase_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          error_o,
  input  logic          ack_i,
  output logic          flash_ce_no,
  output logic          flash_oe_no,
  output logic          flash_we_no,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [DW-1:0] flash_dq_i
);
  localparam int TO_MAX = (PROG_TO_CYC > ERASE_TO_CYC) ? PROG_TO_CYC : ERASE_TO_CYC;
  localparam int TO_W   = $clog2(TO_MAX + 1);
  localparam int RW     = $clog2(MAX_RETRY + 2);
  localparam int UW     = $clog2(UNLK_LEN);

  seq_state_e    state_q;
  logic          erase_q, unlocked_q, issued_q, err_q;
  logic          have_prev_q, prev6_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [UW-1:0] uidx_q;
  logic [RW-1:0] retry_q;

  logic          cyc_need, cyc_start, cyc_wr, cyc_done;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data, cyc_rdata;
  logic          exp7, poll_hit, to_expired;

  always_comb begin
    cyc_need = 1'b0;
    cyc_wr   = 1'b0;
    cyc_addr = addr_q;
    cyc_data = DW'(CMD_CANCEL);
    case (state_q)
      S_UNLK: begin
        cyc_need = 1'b1;
        cyc_addr = AW'(unlock_addr(3'(uidx_q)));
      end
      S_SETUPW: begin
        cyc_need = 1'b1;
        cyc_wr   = 1'b1;
        cyc_data = erase_q ? DW'(CMD_ERASE) : DW'(CMD_PROG);
      end
      S_EXECW: begin
        cyc_need = 1'b1;
        cyc_wr   = 1'b1;
        cyc_data = erase_q ? DW'(CMD_CONFIRM) : data_q;
      end
      S_POLL: cyc_need = 1'b1;
      S_CANCEL: begin
        cyc_need = 1'b1;
        cyc_wr   = 1'b1;
      end
      default: ;
    endcase
  end

  assign cyc_start = cyc_need && !issued_q;
  assign exp7      = erase_q ? 1'b1 : data_q[DW-1];
  assign poll_hit  = (cyc_rdata[DW-1] == exp7) || (have_prev_q && cyc_rdata[DW-2] == prev6_q);

  flash_bus_cycle #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
  ) i_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cyc_start),
    .wr_i    (cyc_wr),
    .addr_i  (cyc_addr),
    .wdata_i (cyc_data),
    .done_o  (cyc_done),
    .rdata_o (cyc_rdata),
    .ce_no   (flash_ce_no),
    .oe_no   (flash_oe_no),
    .we_no   (flash_we_no),
    .addr_o  (flash_addr_o),
    .dq_o    (flash_dq_o),
    .dq_oe_o (flash_dq_oe_o),
    .dq_i    (flash_dq_i)
  );

  flash_timeout #(.CW(TO_W)) i_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == S_EXECW && cyc_done),
    .en_i      (state_q == S_POLL),
    .limit_i   (erase_q ? TO_W'(ERASE_TO_CYC) : TO_W'(PROG_TO_CYC)),
    .expired_o (to_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      erase_q     <= 1'b0;
      unlocked_q  <= 1'b0;
      issued_q    <= 1'b0;
      err_q       <= 1'b0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      uidx_q      <= '0;
      retry_q     <= '0;
    end else begin
      if (cyc_start)     issued_q <= 1'b1;
      else if (cyc_done) issued_q <= 1'b0;

      case (state_q)
        S_IDLE: if (req_valid_i) begin
          erase_q <= req_erase_i;
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          err_q   <= 1'b0;
          retry_q <= '0;
          uidx_q  <= '0;
          state_q <= unlocked_q ? S_SETUPW : S_UNLK;
        end
        S_UNLK: if (cyc_done) begin
          if (uidx_q == UW'(UNLK_LEN - 1)) begin
            unlocked_q <= 1'b1;
            state_q    <= S_SETUPW;
          end
          uidx_q <= uidx_q + 1'b1;
        end
        S_SETUPW: if (cyc_done) state_q <= S_EXECW;
        S_EXECW: if (cyc_done) begin
          have_prev_q <= 1'b0;
          state_q     <= S_POLL;
        end
        S_POLL: if (cyc_done) begin
          if (poll_hit)        state_q <= S_DONE;
          else if (to_expired) state_q <= S_CANCEL;
          have_prev_q <= 1'b1;
          prev6_q     <= cyc_rdata[DW-2];
        end
        S_CANCEL: if (cyc_done) begin
          if (erase_q && retry_q < RW'(MAX_RETRY)) begin
            retry_q <= retry_q + 1'b1;
            state_q <= S_SETUPW;
          end else begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_DONE: if (ack_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign error_o = done_o && err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          done_o,
  input logic          error_o,
  input logic          ack_i,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq,
  input logic          dq_oe
);
  assert_we_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n |-> (!ce_n && oe_n));
  assert_addr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n && $past(!we_n)) |-> $stable(addr));
  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n && $past(!we_n)) |-> $stable(dq));
  assert_ce_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n) |-> ($past(we_n) && $past(oe_n)));
  assert_no_drive_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> oe_n);
  assert_bus_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n |-> !dq_oe);
  assert_err_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);
  assert_ready_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));
  assert_done_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> done_o);
endmodule

bind flash_pe_seq flash_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_o (ready_o),
  .done_o  (done_o),
  .error_o (error_o),
  .ack_i   (ack_i),
  .ce_n    (flash_ce_no),
  .oe_n    (flash_oe_no),
  .we_n    (flash_we_no),
  .addr    (flash_addr_o),
  .dq      (flash_dq_o),
  .dq_oe   (flash_dq_oe_o)
);

// File: tb/test_flash_pe_seq.sv
`timescale 1ns/1ps
module test_flash_pe_seq;
  localparam int AW = 19, DW = 8, RETRY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_erase = 0, ack = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic ready, done, err, ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_dq_o, rd_val = '0;

  always #4 clk = ~clk;

  flash_pe_seq #(
    .AW(AW), .DW(DW), .T_SETUP(1), .T_PULSE(2), .T_HOLD(1),
    .PROG_TO_CYC(100), .ERASE_TO_CYC(200), .MAX_RETRY(RETRY)
  ) i_flash_pe_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_erase_i(req_erase),
    .req_addr_i(req_addr), .req_data_i(req_data), .ready_o(ready), .done_o(done),
    .error_o(err), .ack_i(ack), .flash_ce_no(ce_n), .flash_oe_no(oe_n),
    .flash_we_no(we_n), .flash_addr_o(f_addr), .flash_dq_o(f_dq_o),
    .flash_dq_oe_o(dq_oe), .flash_dq_i(rd_val)
  );

  int checks = 0, errors = 0;
  string tag = "";

  typedef struct { logic [7:0] d; logic [18:0] a; bit chk_a; } wr_t;
  wr_t exp_q[$];

  // flash model state
  bit armed = 0, busy = 0, tog = 0, seen_write = 0;
  int mode = 0, busy_n = 0, busy_left = 0, fail_left = 0, reads_cnt = 0, reads_at_wr = 0;
  logic [7:0] prev_cmd = 8'h00, exp_b = 8'h00;
  logic [18:0] raddr[8];
  logic [18:0] wa;

  always @(negedge we_n) if (armed) wa = f_addr;

  // monitor: pops expected writes at each WE rising edge
  always @(posedge we_n) if (armed) begin
    wr_t e;
    checks++;
    if (!seen_write) begin seen_write = 1; reads_at_wr = reads_cnt; end
    if (ce_n !== 1'b0 || oe_n !== 1'b1 || f_addr !== wa) begin
      errors++;
      $display("FAIL R5 %s: strobe order ce=%b oe=%b addr=%h exp ce=0 oe=1 addr=%h", tag, ce_n, oe_n, f_addr, wa);
    end else if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R11 %s: unexpected write %h@%h, expected none", tag, f_dq_o, f_addr);
    end else begin
      e = exp_q.pop_front();
      if (f_dq_o !== e.d || (e.chk_a && f_addr !== e.a)) begin
        errors++;
        $display("FAIL R3/R4/R9 %s: write %h@%h, expected %h@%h", tag, f_dq_o, f_addr, e.d, e.a);
      end
    end
    if (f_dq_o == 8'hFF) begin
      busy = 0; prev_cmd = 8'h00;
    end else if (prev_cmd == 8'h10 || prev_cmd == 8'h20) begin
      busy = 1; tog = 0;
      exp_b = (prev_cmd == 8'h10) ? f_dq_o : 8'hFF;
      if (fail_left > 0) begin fail_left--; busy_left = 1000000; end
      else busy_left = busy_n;
      prev_cmd = 8'h00;
    end else prev_cmd = f_dq_o;
  end

  always @(negedge oe_n) if (armed) begin
    if (reads_cnt < 8) raddr[reads_cnt] = f_addr;
    reads_cnt++;
    if (busy) begin
      checks++;
      if (f_addr !== req_addr || we_n !== 1'b1) begin
        errors++;
        $display("FAIL R12 %s: poll at %h we=%b, expected %h we=1", tag, f_addr, we_n, req_addr);
      end
      if (busy_left > 0) begin
        busy_left--; rd_val = {~exp_b[7], tog, 6'b0}; tog = ~tog;
      end else if (mode == 0) begin
        rd_val = {exp_b[7], tog, exp_b[5:0]}; tog = ~tog;
      end else rd_val = {~exp_b[7], 1'b0, exp_b[5:0]};
    end else rd_val = 8'h00;
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", what, tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [18:0] a, input bit c);
    wr_t e; e.d = d; e.a = a; e.chk_a = c; exp_q.push_back(e);
  endtask

  // driver: pushes the expected write stream, then runs one request
  task automatic run_op(input bit erase, input logic [18:0] a, input logic [7:0] d,
                        input int md, input int fails, input bit unl, input string t);
    bit exp_err;
    int nfail;
    tag = t; mode = md; busy_n = 3; fail_left = fails;
    reads_cnt = 0; seen_write = 0;
    if (erase) begin
      nfail = (fails > RETRY) ? RETRY + 1 : fails;
      for (int i = 0; i < nfail; i++) begin push(8'h20, a, 0); push(8'hD0, a, 1); push(8'hFF, a, 0); end
      if (fails <= RETRY) begin push(8'h20, a, 0); push(8'hD0, a, 1); end
      exp_err = (fails > RETRY);
    end else begin
      push(8'h10, a, 0); push(d, a, 1);
      if (fails > 0) push(8'hFF, a, 0);
      exp_err = (fails > 0);
    end
    @(negedge clk);
    req_valid = 1; req_erase = erase; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    chk(done === 1'b1, "R7/R8 done reached", done, 1);
    chk(err === exp_err, exp_err ? "R9/R10 error" : "R7/R8 no error", err, exp_err);
    chk(exp_q.size() == 0, "R3/R4 writes left", exp_q.size(), 0);
    chk(reads_at_wr == (unl ? 7 : 0), "R2 unlock reads", reads_at_wr, unl ? 7 : 0);
    if (unl) begin
      logic [18:0] ul[7] = '{19'h01823, 19'h01820, 19'h01822, 19'h00418, 19'h01B23, 19'h00419, 19'h0041A};
      for (int i = 0; i < 7; i++) chk(raddr[i] === ul[i], "R2 unlock addr", raddr[i], ul[i]);
    end
    // R11: request while done is ignored
    chk(ready === 1'b0, "R11 ready low during done", ready, 0);
    req_valid = 1; req_erase = 0; req_data = 8'h77;
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R11 done held", done, 1);
    req_valid = 0; ack = 1;
    @(negedge clk);
    ack = 0;
    chk(done === 1'b0 && ready === 1'b1, "R11 ack returns idle", {done, ready}, 2'b01);
    repeat (40) @(negedge clk);
    chk(ce_n === 1'b1 && dq_oe === 1'b0, "R11/R6 bus idle after ack", {ce_n, dq_oe}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "reset";
    chk(ce_n === 1 && oe_n === 1 && we_n === 1, "R1 strobes high", {ce_n, oe_n, we_n}, 3'b111);
    chk(dq_oe === 0 && done === 0 && ready === 1, "R1 idle state", {dq_oe, done, ready}, 3'b001);
    rst_n = 1; armed = 1;
    repeat (2) @(negedge clk);
    run_op(0, 19'h51234, 8'hA5, 0, 0, 1, "R4 program data-poll");
    run_op(0, 19'h00F0F, 8'h3C, 1, 0, 0, "R8 program toggle-only");
    run_op(1, 19'h72A55, 8'h00, 0, 0, 0, "R3 erase data-poll");
    run_op(1, 19'h10301, 8'h00, 1, 0, 0, "R8 erase toggle-only");
    run_op(1, 19'h3FF80, 8'h00, 0, 1, 0, "R9 erase retry ok");
    run_op(1, 19'h00200, 8'h00, 0, 9, 0, "R9 erase retries exhausted");
    run_op(0, 19'h7FFFF, 8'h80, 0, 1, 0, "R10 program timeout");
    run_op(0, 19'h00001, 8'h01, 0, 0, 0, "R7 program after error");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule